// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block steps through a list of transmit descriptors kept in system memory and hands each owned buffer to a frame source. Each descriptor takes 32 bytes. The block reads only the first four words of a descriptor: a control/status word, a size word, a buffer pointer and a link pointer. The four words that follow are left for a timestamp, and the block never touches them.

Raising `run` loads the list base address and starts the walk. For each descriptor, the walker reads the control word first. If the CPU owns the entry, the walker stops in a suspended state, raises a one-cycle buffer-unavailable pulse and waits for a poll demand. If the hardware owns the entry, the walker reads the other three words and offers the buffer to the frame source. When the frame source reports completion, the walker writes the status word back to the same location. That write clears ownership and packs the error flags. The walker then moves to the next descriptor, either through the link pointer or to the adjacent 32-byte slot.

Memory is reached through a plain word-addressed port. A read returns its data on the cycle after the request. Software can read the address of the descriptor in progress at any time.

Top module: `tx_desc_walker`

## Requirements
- R1: After reset the walker is idle: no memory request, no frame offered, not suspended, no pulses, and `cur_desc` is 0.
- R2: While idle, a high `run` loads `list_base` into `cur_desc`. On the next cycle the walker issues a read of word address `list_base[AW-1:2]`.
- R3: If word 0 bit 31 (ownership, 1 = hardware) reads 0, the walker enters the suspended state. It raises `buf_unavail` for exactly one cycle and offers no frame.
- R4: For a hardware-owned descriptor, the walker holds `frm_valid` until `frm_done`. While it does, it presents `frm_buf_addr` = word 2, `frm_size` = word 1 bits 12:0, `frm_first` = word 0 bit 28 and `frm_last` = word 0 bit 29, and these stay stable.
- R5: On completion the walker writes word 0 of the same descriptor. The written word has bit 31 cleared and bits 30, 29, 28 and 20 copied from the word read. It places underflow in bit 1, collision count in bits 6:3, excessive collision in bit 8, late collision in bit 9, no carrier in bit 10 and loss of carrier in bit 11. All other bits except 15 are 0.
- R6: Bit 15 of the written status equals the OR of bits 1, 8, 9, 10 and 11. The collision count does not contribute to it.
- R7: `tx_complete` pulses for one cycle, during the write-back, only when word 0 bit 30 was set.
- R8: If word 0 bit 20 is set, the next descriptor is the address in word 3. Otherwise the next descriptor is the current address plus 32.
- R9: A suspended walker stays suspended and issues no memory request even if the descriptor changes. A `poll_demand` pulse makes it read the same descriptor again.
- R10: When `run` is low at the end of a write-back, or while suspended, the walker returns to idle and stops requesting memory.
- R11: `cur_desc` holds the address of the descriptor being processed. No request ever targets words 4 to 7 of a descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Transmit run enable |
| list_base | input | AW | Byte address of the first descriptor |
| poll_demand | input | 1 | Resume request for a suspended walk |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after request |
| frm_valid | output | 1 | Buffer offered to frame source |
| frm_buf_addr | output | AW | Buffer byte address |
| frm_size | output | SIZE_W | Buffer size in bytes |
| frm_first | output | 1 | First segment of frame |
| frm_last | output | 1 | Last segment of frame |
| frm_done | input | 1 | Frame source finished this buffer |
| frm_underflow | input | 1 | Underflow error |
| frm_coll_cnt | input | 4 | Collision count |
| frm_excess_coll | input | 1 | Excessive collision error |
| frm_late_coll | input | 1 | Late collision error |
| frm_no_carrier | input | 1 | No carrier error |
| frm_loss_carrier | input | 1 | Loss of carrier error |
| cur_desc | output | AW | Address of current descriptor |
| suspended | output | 1 | Walker suspended on a CPU-owned entry |
| buf_unavail | output | 1 | One-cycle pulse on suspension |
| tx_complete | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume three things about the environment:
- `frm_done` arrives only while a buffer is offered.
- Read data returns exactly one cycle after the request.
- Descriptors are 32-byte aligned.

The bench keeps within these limits. Its memory model has a fixed one-cycle latency. The frame source drives `frm_done` only after it has seen `frm_valid`. Every descriptor address is a multiple of 32. The bench changes memory only while the walker is suspended or idle, so the words the walker reads always match the bench's predictions.

// File: rtl/tx_desc_walker.sv
module tx_desc_walker #(
  parameter int AW     = 32,
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [AW-1:0]     list_base,
  input  logic              poll_demand,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-3:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              frm_valid,
  output logic [AW-1:0]     frm_buf_addr,
  output logic [SIZE_W-1:0] frm_size,
  output logic              frm_first,
  output logic              frm_last,
  input  logic              frm_done,
  input  logic              frm_underflow,
  input  logic [3:0]        frm_coll_cnt,
  input  logic              frm_excess_coll,
  input  logic              frm_late_coll,
  input  logic              frm_no_carrier,
  input  logic              frm_loss_carrier,
  output logic [AW-1:0]     cur_desc,
  output logic              suspended,
  output logic              buf_unavail,
  output logic              tx_complete
);

  localparam logic [AW-1:0] DESC_BYTES = AW'(32);
  localparam logic [31:0]   KEEP_MASK  = 32'h7010_0000;

  typedef enum logic [3:0] {
    S_IDLE, S_R0, S_R1, S_R2, S_R3, S_R4, S_XFER, S_WB, S_SUSP
  } state_t;

  state_t           state;
  logic [AW-1:0]    cur, nxt;
  logic [31:0]      ctl;
  logic [15:0]      stat;
  logic [AW-1:0]    bufa;
  logic [SIZE_W-1:0] size;
  logic             unav;
  logic [1:0]       off;
  logic             err_any;

  assign err_any = frm_underflow | frm_excess_coll | frm_late_coll
                 | frm_no_carrier | frm_loss_carrier;

  always_comb begin
    mem_req = 1'b0;
    mem_we  = 1'b0;
    off     = 2'd0;
    unique case (state)
      S_R0:  begin mem_req = 1'b1; off = 2'd0; end
      S_R1:  begin mem_req = mem_rdata[31]; off = 2'd1; end
      S_R2:  begin mem_req = 1'b1; off = 2'd2; end
      S_R3:  begin mem_req = 1'b1; off = 2'd3; end
      S_WB:  begin mem_req = 1'b1; mem_we = 1'b1; end
      default: ;
    endcase
  end

  assign mem_addr     = cur[AW-1:2] + (AW-2)'(off);
  assign mem_wdata    = (ctl & KEEP_MASK) | {16'h0, stat};
  assign frm_valid    = (state == S_XFER);
  assign frm_buf_addr = bufa;
  assign frm_size     = size;
  assign frm_first    = ctl[28];
  assign frm_last     = ctl[29];
  assign cur_desc     = cur;
  assign suspended    = (state == S_SUSP);
  assign buf_unavail  = unav;
  assign tx_complete  = (state == S_WB) && ctl[30];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur   <= '0;
      nxt   <= '0;
      ctl   <= '0;
      stat  <= '0;
      bufa  <= '0;
      size  <= '0;
      unav  <= 1'b0;
    end else begin
      unav <= 1'b0;
      unique case (state)
        S_IDLE: if (run) begin
          cur   <= list_base;
          state <= S_R0;
        end
        S_R0: state <= S_R1;
        S_R1: begin
          ctl <= mem_rdata;
          if (mem_rdata[31]) state <= S_R2;
          else begin
            state <= S_SUSP;
            unav  <= 1'b1;
          end
        end
        S_R2: begin size <= mem_rdata[SIZE_W-1:0]; state <= S_R3; end
        S_R3: begin bufa <= mem_rdata[AW-1:0];     state <= S_R4; end
        S_R4: begin nxt  <= mem_rdata[AW-1:0];     state <= S_XFER; end
        S_XFER: if (frm_done) begin
          stat  <= {err_any, 3'b000, frm_loss_carrier, frm_no_carrier,
                    frm_late_coll, frm_excess_coll, 1'b0, frm_coll_cnt,
                    1'b0, frm_underflow, 1'b0};
          state <= S_WB;
        end
        S_WB: begin
          cur   <= ctl[20] ? nxt : cur + DESC_BYTES;
          state <= run ? S_R0 : S_IDLE;
        end
        S_SUSP: begin
          if (!run)             state <= S_IDLE;
          else if (poll_demand) state <= S_R0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_WB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (!mem_wdata[31] && mem_addr[2:0] == 3'd0)); // R5
  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[15] == |{mem_wdata[1], mem_wdata[11:8]})); // R6
  AST_UNAVAIL_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    buf_unavail |-> (suspended && !frm_valid && !mem_req)); // R3
  AST_UNAVAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_unavail |=> !buf_unavail); // R3
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_done) |=> (frm_valid && $stable(frm_buf_addr) && $stable(frm_size))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_complete |=> !tx_complete); // R7
  AST_NO_STAMP_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[2]); // R11
  AST_SUSPEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !mem_req); // R9

endmodule

// File: tb/tx_desc_walker_bench.sv
module tx_desc_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [AW-1:0] list_base = '0;
  logic poll_demand = 1'b0;
  logic mem_req, mem_we;
  logic [AW-3:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic frm_valid, frm_first, frm_last;
  logic [AW-1:0] frm_buf_addr;
  logic [12:0] frm_size;
  logic frm_done = 1'b0, frm_underflow = 1'b0, frm_excess_coll = 1'b0;
  logic frm_late_coll = 1'b0, frm_no_carrier = 1'b0, frm_loss_carrier = 1'b0;
  logic [3:0] frm_coll_cnt = '0;
  logic [AW-1:0] cur_desc;
  logic suspended, buf_unavail, tx_complete;

  int checks = 0, errors = 0, stamp_hits = 0;
  bit finished = 0;
  logic [31:0] mem [0:255];
  logic [AW-1:0] exp_addr;
  logic [AW-1:0] slots [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_desc_walker u_tx_desc_walker (
    .clk(clk), .rst_n(rst_n), .run(run), .list_base(list_base),
    .poll_demand(poll_demand), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .frm_valid(frm_valid), .frm_buf_addr(frm_buf_addr), .frm_size(frm_size),
    .frm_first(frm_first), .frm_last(frm_last), .frm_done(frm_done),
    .frm_underflow(frm_underflow), .frm_coll_cnt(frm_coll_cnt),
    .frm_excess_coll(frm_excess_coll), .frm_late_coll(frm_late_coll),
    .frm_no_carrier(frm_no_carrier), .frm_loss_carrier(frm_loss_carrier),
    .cur_desc(cur_desc), .suspended(suspended), .buf_unavail(buf_unavail),
    .tx_complete(tx_complete)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_addr[2]) stamp_hits <= stamp_hits + 1;
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wb_exp(input logic [31:0] w0, input bit und,
      input logic [3:0] cnt, input bit exc, input bit late, input bit noc, input bit loss);
    logic [31:0] w;
    w = w0 & 32'h7010_0000;
    w[1] = und; w[6:3] = cnt; w[8] = exc; w[9] = late; w[10] = noc; w[11] = loss;
    w[15] = und | exc | late | noc | loss;
    return w;
  endfunction

  task automatic put_desc(input logic [AW-1:0] a, input logic [31:0] w0,
                          input logic [31:0] sz, input logic [31:0] b, input logic [31:0] n);
    mem[a[9:2]] = w0; mem[a[9:2]+8'd1] = sz; mem[a[9:2]+8'd2] = b; mem[a[9:2]+8'd3] = n;
    for (int k = 4; k < 8; k++) mem[a[9:2]+8'(k)] = 32'hDEAD_0000 | 32'(k);
  endtask

  task automatic step(input bit stop_at_end, output bit susp);
    logic [31:0] w0, w1, w2, w3, e;
    bit und, exc, late, noc, loss;
    logic [3:0] cnt;
    int n;
    w0 = mem[exp_addr[9:2]]; w1 = mem[exp_addr[9:2]+8'd1];
    w2 = mem[exp_addr[9:2]+8'd2]; w3 = mem[exp_addr[9:2]+8'd3];
    n = 0;
    while (!frm_valid && !buf_unavail && n < 100) begin @(negedge clk); n++; end
    chk(cur_desc == exp_addr, "R11", "cur_desc", cur_desc, exp_addr);
    if (!w0[31]) begin
      susp = 1;
      chk(buf_unavail == 1'b1, "R3", "buf_unavail", 32'(buf_unavail), 1);
      chk(suspended == 1'b1 && frm_valid == 1'b0, "R3", "suspend/no frame",
          {suspended, frm_valid}, 2'b10);
      @(negedge clk);
      chk(buf_unavail == 1'b0, "R3", "pulse width", 32'(buf_unavail), 0);
      return;
    end
    susp = 0;
    chk(frm_valid == 1'b1, "R4", "frm_valid", 32'(frm_valid), 1);
    chk(frm_buf_addr == w2, "R4", "buf addr", frm_buf_addr, w2);
    chk(frm_size == w1[12:0], "R4", "size", 32'(frm_size), 32'(w1[12:0]));
    chk({frm_first, frm_last} == {w0[28], w0[29]}, "R4", "first/last",
        {frm_first, frm_last}, {w0[28], w0[29]});
    repeat ($urandom_range(0, 3)) @(negedge clk);
    und = ($urandom_range(0, 3) == 0); exc = ($urandom_range(0, 3) == 0);
    late = ($urandom_range(0, 3) == 0); noc = ($urandom_range(0, 3) == 0);
    loss = ($urandom_range(0, 3) == 0); cnt = 4'($urandom_range(0, 15));
    frm_underflow = und; frm_excess_coll = exc; frm_late_coll = late;
    frm_no_carrier = noc; frm_loss_carrier = loss; frm_coll_cnt = cnt;
    frm_done = 1'b1;
    if (stop_at_end) run = 1'b0;
    @(negedge clk);
    frm_done = 1'b0;
    e = wb_exp(w0, und, cnt, exc, late, noc, loss);
    chk(mem_req && mem_we, "R5", "write-back issued", {mem_req, mem_we}, 2'b11);
    chk(mem_addr == exp_addr[AW-1:2], "R5", "write-back addr", 32'(mem_addr), 32'(exp_addr[AW-1:2]));
    chk(mem_wdata == e, "R5", "status word", mem_wdata, e);
    chk(mem_wdata[15] == (und | exc | late | noc | loss), "R6", "error summary",
        32'(mem_wdata[15]), 32'(und | exc | late | noc | loss));
    chk(tx_complete == w0[30], "R7", "tx_complete", 32'(tx_complete), 32'(w0[30]));
    exp_addr = w0[20] ? w3 : exp_addr + 32'd32;
    @(negedge clk);
    chk(tx_complete == 1'b0, "R7", "tx_complete pulse", 32'(tx_complete), 0);
  endtask

  task automatic check_idle(input string req);
    for (int k = 0; k < 5; k++) begin
      chk(!mem_req && !frm_valid && !suspended, req, "idle quiet",
          {mem_req, frm_valid, suspended}, 0);
      @(negedge clk);
    end
  endtask

  task automatic start_at(input logic [AW-1:0] base);
    list_base = base; run = 1'b1; exp_addr = base;
    @(negedge clk);
    chk(mem_req && !mem_we && mem_addr == base[AW-1:2], "R2", "first read",
        32'(mem_addr), 32'(base[AW-1:2]));
    chk(cur_desc == base, "R2", "cur_desc load", cur_desc, base);
  endtask

  initial begin
    bit s;
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!mem_req && !frm_valid && !suspended && !buf_unavail && !tx_complete,
        "R1", "reset outputs", {mem_req, frm_valid, suspended, buf_unavail, tx_complete}, 0);
    chk(cur_desc == '0, "R1", "reset cur_desc", cur_desc, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    // directed chained ring 0x040 -> 0x200 -> 0x0A0 -> 0x300 -> 0x040 (R8)
    put_desc(32'h040, 32'hD010_0000, 32'd100,  32'h1000_0000, 32'h200);
    put_desc(32'h200, 32'h8010_0000, 32'd1514, 32'h1000_0800, 32'h0A0);
    put_desc(32'h0A0, 32'hC010_0000, 32'h1FFF, 32'h2000_0000, 32'h300);
    put_desc(32'h300, 32'hA010_0000, 32'd0,    32'h3000_0004, 32'h040);
    start_at(32'h040);
    for (int i = 0; i < 4; i++) begin
      step(0, s);
      chk(s == 0, "R8", "chain follow", 32'(s), 0);
    end
    step(0, s);
    chk(s == 1 && cur_desc == 32'h040, "R3", "suspend on released entry", cur_desc, 32'h040);

    // R9: ownership change alone does not resume
    put_desc(32'h040, 32'h9010_0000, 32'd64, 32'h4000_0000, 32'h100);
    repeat (6) begin
      @(negedge clk);
      chk(suspended && !mem_req, "R9", "stay suspended without poll", {suspended, mem_req}, 2'b10);
    end
    poll_demand = 1'b1; @(negedge clk); poll_demand = 1'b0;
    chk(cur_desc == 32'h040, "R9", "poll rereads same entry", cur_desc, 32'h040);

    // sequential entries 0x100,0x120,0x140, then CPU-owned 0x160 (R8)
    put_desc(32'h100, 32'h8000_0000, 32'd10, 32'h5000_0000, 32'h0);
    put_desc(32'h120, 32'hC000_0000, 32'd20, 32'h5000_0100, 32'h0);
    put_desc(32'h140, 32'hA000_0000, 32'd30, 32'h5000_0200, 32'h0);
    put_desc(32'h160, 32'h3000_0000, 32'd40, 32'h5000_0300, 32'h0);
    for (int i = 0; i < 4; i++) step(0, s);
    step(0, s);
    chk(s == 1 && cur_desc == 32'h160, "R8", "sequential advance to +32", cur_desc, 32'h160);

    // R10: dropping run while suspended returns to idle
    run = 1'b0;
    @(negedge clk); @(negedge clk);
    check_idle("R10");

    slots[0] = 32'h180; slots[1] = 32'h1C0; slots[2] = 32'h240; slots[3] = 32'h280;
    slots[4] = 32'h2C0; slots[5] = 32'h340; slots[6] = 32'h380; slots[7] = 32'h3C0;
    for (int r = 0; r < 15; r++) begin
      int st, sd, done_cnt;
      st = $urandom_range(0, 7);
      sd = ($urandom_range(0, 1) == 1) ? 3 : 1;
      for (int i = 0; i < 8; i++) begin
        logic [31:0] w0;
        w0 = $urandom & 32'h0FEF_FFFF;
        w0[31] = ($urandom_range(0, 4) != 0);
        w0[30] = $urandom_range(0, 1); w0[29] = $urandom_range(0, 1);
        w0[28] = $urandom_range(0, 1); w0[20] = 1'b1;
        put_desc(slots[(st + i*sd) % 8], w0, $urandom, $urandom,
                 slots[(st + (i+1)*sd) % 8]);
      end
      start_at(slots[st]);
      done_cnt = 0;
      while (done_cnt < 6) begin
        step(done_cnt == 5, s);
        if (s) begin
          mem[exp_addr[9:2]][31] = 1'b1;
          poll_demand = 1'b1; @(negedge clk); poll_demand = 1'b0;
        end else done_cnt++;
      end
      check_idle("R10");
    end

    chk(stamp_hits == 0, "R11", "timestamp words never accessed", stamp_hits, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule